// File: doc/BRIEF.md
# Programming-Mode Memory with Address Counter

This block models the nonvolatile word store that an external programmer sees while a device sits in its program/verify mode. It has a 2048-word user array and a 64-word configuration array. Every word is 14 bits wide. A single 14-bit address counter selects the word. Its top bit chooses the region: user space when clear, configuration space when set. One-cycle command strobes move the counter, read the word it points at, program that word, or start a bulk erase.

The counter wraps inside its current region, so a programmer that enters configuration space cannot walk back into user space without a reset command. Only part of each region is backed by storage. Only some configuration words are usable: the ID words, the configuration word and the two calibration words. Every other address reads as the erased value, and a write to it raises an error pulse. Bulk erase returns every word to the erased state except the two calibration words, which keep their contents.

Top module: `pgm_mem_top`

## Requirements
- R1: After rst_n is released: addr is 0x0000, busy is 0, wr_err is 0 and rd_valid is 0. Every backed word holds 0x3FFF, except 0x2008, which holds CAL_WORD0, and 0x2009, which holds CAL_WORD1.
- R2: cmd_reset loads addr with 0x0000 and cmd_cfg loads it with 0x2000. When strobes arrive in the same cycle, cmd_reset wins over cmd_cfg, and cmd_cfg wins over cmd_inc.
- R3: In user space, cmd_inc advances addr by one, and 0x1FFF wraps to 0x0000.
- R4: In configuration space, cmd_inc advances addr by one, and 0x3FFF wraps to 0x2000. Bit 13 of addr stays 1 until cmd_reset or rst_n.
- R5: cmd_inc has no effect in a cycle where cmd_write is also asserted.
- R6: cmd_read sets rd_valid for one cycle on the next clock edge. rd_data then holds the word at the address the counter had when the strobe was sampled.
- R7: Reads of unbacked addresses (0x0800–0x1FFF, 0x2040–0x3FFF) and of reserved addresses (0x2004–0x2006, 0x200A–0x203F) return 0x3FFF.
- R8: cmd_write stores all 14 bits of wr_data at a usable address (0x0000–0x07FF, 0x2000–0x2003, 0x2007–0x2009), and a later read returns that value.
- R9: A cmd_write to an unbacked or reserved address changes nothing and raises wr_err for exactly the next cycle.
- R10: Bulk erase sets every user word and the configuration words 0x2000–0x2003 and 0x2007 to 0x3FFF. The words at 0x2008 and 0x2009 keep their values.
- R11: After a cmd_erase, busy is high for exactly ERASE_CYCLES cycles. While busy is high, the cmd_read, cmd_write and cmd_erase strobes are ignored: no rd_valid, no wr_err, no stored change and no extension of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_reset | input | 1 | Clear the address counter to 0x0000 |
| cmd_cfg | input | 1 | Load the address counter with 0x2000 |
| cmd_inc | input | 1 | Advance the address counter within its region |
| cmd_read | input | 1 | Read the word at the counter address |
| cmd_write | input | 1 | Program wr_data at the counter address |
| cmd_erase | input | 1 | Start a bulk erase |
| wr_data | input | 14 | Word to program |
| addr | output | 14 | Current counter value |
| rd_data | output | 14 | Word returned by the last read |
| rd_valid | output | 1 | rd_data was updated on the last edge |
| wr_err | output | 1 | Last write targeted an unusable address |
| busy | output | 1 | Bulk erase in progress |

## Verification
The hardest states to reach are the two wrap points at 0x1FFF and 0x3FFF. The counter only moves by one per strobe and the backed storage ends far below either point. The bench reaches each one by loading the region base and issuing 8191 increment strobes. It then checks the wrap and that the region bit stays set. The second hard case is a strobe arriving in the middle of an erase. The bench overlaps a second erase, a write and a read with a running erase, then confirms that busy keeps its length and that the stored word is untouched.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef logic [13:0] addr_t;
  typedef logic [13:0] word_t;

  localparam word_t ERASED    = 14'h3FFF;
  localparam addr_t USER_BASE = 14'h0000;
  localparam addr_t CFG_BASE  = 14'h2000;
  localparam int    ID_LAST   = 3;
  localparam int    CFGW_IDX  = 7;
  localparam int    CAL_IDX0  = 8;
  localparam int    CAL_IDX1  = 9;

  // Next counter value: the region bit is carried, the offset wraps.
  function automatic addr_t step_addr(addr_t a);
    return {a[13], a[12:0] + 13'd1};
  endfunction

  // True when the address is backed by storage and not reserved.
  function automatic logic is_usable(addr_t a, int user_depth, int cfg_depth);
    int off;
    off = int'(a[12:0]);
    if (!a[13]) return off < user_depth;
    return (off < cfg_depth) && ((off <= ID_LAST) || (off >= CFGW_IDX && off <= CAL_IDX1));
  endfunction

  // Calibration words survive bulk erase.
  function automatic logic is_cal(int idx);
    return (idx == CAL_IDX0) || (idx == CAL_IDX1);
  endfunction
endpackage

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr
  import pgm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_reset,
  input  logic  cmd_cfg,
  input  logic  cmd_inc,
  input  logic  cmd_write,
  output addr_t addr
);
  logic inc_go;
  assign inc_go = cmd_inc && !cmd_write && !cmd_reset && !cmd_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n)         addr <= USER_BASE;
    else if (cmd_reset) addr <= USER_BASE;
    else if (cmd_cfg)   addr <= CFG_BASE;
    else if (inc_go)    addr <= step_addr(addr);
  end

  a_r3_user_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_go && addr == 14'h1FFF) |=> addr == 14'h0000);
  a_r4_cfg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_go && addr == 14'h3FFF) |=> addr == 14'h2000);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[13] && !cmd_reset) |=> addr[13]);
  a_r5_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && !cmd_reset && !cmd_cfg) |=> $stable(addr));
  a_r2_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> addr == 14'h0000);
endmodule

// File: rtl/pgm_erase_seq.sv
module pgm_erase_seq #(
  parameter int ERASE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic erase_go
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  assign busy     = cnt != '0;
  assign erase_go = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (erase_go) cnt <= CNT_W'(ERASE_CYCLES);
    else if (busy)     cnt <= cnt - 1'b1;
  end

  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CNT_W'(1)) |=> busy);
  a_r11_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/pgm_word_store.sv
module pgm_word_store
  import pgm_pkg::*;
#(
  parameter int    USER_DEPTH = 2048,
  parameter int    CFG_DEPTH  = 64,
  parameter word_t CAL_WORD0  = 14'h2A5C,
  parameter word_t CAL_WORD1  = 14'h15A3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t addr,
  input  logic  rd_en,
  input  logic  wr_en,
  input  word_t wr_data,
  input  logic  erase_go,
  output word_t rd_data,
  output logic  rd_valid,
  output logic  wr_err
);
  localparam int UI_W = $clog2(USER_DEPTH);
  localparam int CI_W = $clog2(CFG_DEPTH);

  word_t user_mem [USER_DEPTH];
  word_t cfg_mem  [CFG_DEPTH];

  logic            usable;
  logic [UI_W-1:0] ui;
  logic [CI_W-1:0] ci;
  word_t           cur_word;

  assign usable   = is_usable(addr, USER_DEPTH, CFG_DEPTH);
  assign ui       = addr[UI_W-1:0];
  assign ci       = addr[CI_W-1:0];
  assign cur_word = addr[13] ? cfg_mem[ci] : user_mem[ui];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_DEPTH; i++) user_mem[i] <= ERASED;
      for (int j = 0; j < CFG_DEPTH; j++)
        cfg_mem[j] <= (j == CAL_IDX0) ? CAL_WORD0 : (j == CAL_IDX1) ? CAL_WORD1 : ERASED;
      rd_data  <= ERASED;
      rd_valid <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      wr_err   <= wr_en && !usable;
      if (rd_en) rd_data <= usable ? cur_word : ERASED;
      if (erase_go) begin
        for (int i = 0; i < USER_DEPTH; i++) user_mem[i] <= ERASED;
        for (int j = 0; j < CFG_DEPTH; j++)
          if (!is_cal(j)) cfg_mem[j] <= ERASED;
      end else if (wr_en && usable) begin
        if (addr[13]) cfg_mem[ci]  <= wr_data;
        else          user_mem[ui] <= wr_data;
      end
    end
  end

  a_r10_cal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (cfg_mem[CAL_IDX0] == $past(cfg_mem[CAL_IDX0]) &&
                  cfg_mem[CAL_IDX1] == $past(cfg_mem[CAL_IDX1])));
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en));
  a_r6_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  a_r7_unusable_reads_erased: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !usable) |=> rd_data == ERASED);
endmodule

// File: rtl/pgm_mem_top.sv
module pgm_mem_top
  import pgm_pkg::*;
#(
  parameter int           USER_DEPTH   = 2048,
  parameter int           CFG_DEPTH    = 64,
  parameter int           ERASE_CYCLES = 10,
  parameter logic [13:0]  CAL_WORD0    = 14'h2A5C,
  parameter logic [13:0]  CAL_WORD1    = 14'h15A3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_reset,
  input  logic        cmd_cfg,
  input  logic        cmd_inc,
  input  logic        cmd_read,
  input  logic        cmd_write,
  input  logic        cmd_erase,
  input  logic [13:0] wr_data,
  output logic [13:0] addr,
  output logic [13:0] rd_data,
  output logic        rd_valid,
  output logic        wr_err,
  output logic        busy
);
  logic erase_go;
  logic rd_en;
  logic wr_en;

  assign rd_en = cmd_read  && !busy;
  assign wr_en = cmd_write && !busy;

  pgm_addr_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_reset (cmd_reset),
    .cmd_cfg   (cmd_cfg),
    .cmd_inc   (cmd_inc),
    .cmd_write (cmd_write),
    .addr      (addr)
  );

  pgm_erase_seq #(.ERASE_CYCLES(ERASE_CYCLES)) u_erase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_erase),
    .busy     (busy),
    .erase_go (erase_go)
  );

  pgm_word_store #(
    .USER_DEPTH (USER_DEPTH),
    .CFG_DEPTH  (CFG_DEPTH),
    .CAL_WORD0  (CAL_WORD0),
    .CAL_WORD1  (CAL_WORD1)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .erase_go (erase_go),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .wr_err   (wr_err)
  );

  a_r11_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!rd_valid && !wr_err));
endmodule

// File: tb/tb_pgm_mem_top.sv
`timescale 1ns/1ps
module tb_pgm_mem_top;
  localparam int          E    = 10;
  localparam logic [13:0] CAL0 = 14'h2A5C;
  localparam logic [13:0] CAL1 = 14'h15A3;

  // {target addr, write data, expect error, expected readback}
  localparam logic [42:0] VEC [11] = '{
    {14'h0000, 14'h0ABC, 1'b0, 14'h0ABC},
    {14'h0005, 14'h1555, 1'b0, 14'h1555},
    {14'h07FF, 14'h2AAA, 1'b0, 14'h2AAA},
    {14'h0800, 14'h0001, 1'b1, 14'h3FFF},
    {14'h2000, 14'h007F, 1'b0, 14'h007F},
    {14'h2003, 14'h3F12, 1'b0, 14'h3F12},
    {14'h2005, 14'h0000, 1'b1, 14'h3FFF},
    {14'h2007, 14'h0C3A, 1'b0, 14'h0C3A},
    {14'h2009, 14'h1234, 1'b0, 14'h1234},
    {14'h203F, 14'h0002, 1'b1, 14'h3FFF},
    {14'h2040, 14'h0003, 1'b1, 14'h3FFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_reset = 1'b0, cmd_cfg = 1'b0, cmd_inc = 1'b0;
  logic cmd_read = 1'b0, cmd_write = 1'b0, cmd_erase = 1'b0;
  logic [13:0] wr_data = '0;
  logic [13:0] addr, rd_data;
  logic rd_valid, wr_err, busy;

  int nchecks = 0;
  int nerr    = 0;
  int ncyc    = 0;

  always #2.5 clk = ~clk;

  pgm_mem_top #(.ERASE_CYCLES(E), .CAL_WORD0(CAL0), .CAL_WORD1(CAL1)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_cfg(cmd_cfg),
    .cmd_inc(cmd_inc), .cmd_read(cmd_read), .cmd_write(cmd_write),
    .cmd_erase(cmd_erase), .wr_data(wr_data), .addr(addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .wr_err(wr_err), .busy(busy)
  );

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      nerr++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected completion", ncyc);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock with the given strobes; returns 1 ns after the edge.
  task automatic cyc(input logic r, input logic c, input logic i, input logic rd,
                     input logic w, input logic e, input logic [13:0] d);
    cmd_reset = r; cmd_cfg = c; cmd_inc = i; cmd_read = rd;
    cmd_write = w; cmd_erase = e; wr_data = d;
    @(posedge clk); #1;
    cmd_reset = 0; cmd_cfg = 0; cmd_inc = 0; cmd_read = 0;
    cmd_write = 0; cmd_erase = 0; wr_data = '0;
  endtask

  task automatic idle();   cyc(0,0,0,0,0,0,'0); endtask
  task automatic inc1();   cyc(0,0,1,0,0,0,'0); endtask
  task automatic rd1();    cyc(0,0,0,1,0,0,'0); endtask

  task automatic go_to(input logic [13:0] a);
    if (a[13]) cyc(0,1,0,0,0,0,'0); else cyc(1,0,0,0,0,0,'0);
    for (int k = 0; k < int'(a[12:0]); k++) inc1();
  endtask

  task automatic read_at(input string req, input logic [13:0] a, input logic [13:0] exp);
    go_to(a);
    rd1();
    check({req, " rd_valid"}, rd_valid, 1);
    check({req, " rd_data"}, rd_data, exp);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: state right after reset
    check("R1 addr", addr, 14'h0000);
    check("R1 busy", busy, 0);
    check("R1 wr_err", wr_err, 0);
    check("R1 rd_valid", rd_valid, 0);
    read_at("R1 cal0", 14'h2008, CAL0);
    read_at("R1 cal1", 14'h2009, CAL1);
    read_at("R1 user erased", 14'h0100, 14'h3FFF);
    idle();
    check("R6 valid one cycle", rd_valid, 0);

    // R2: command priority
    cyc(0,1,0,0,0,0,'0);
    cyc(1,1,1,0,0,0,'0);
    check("R2 reset wins", addr, 14'h0000);
    cyc(0,1,1,0,0,0,'0);
    check("R2 cfg wins over inc", addr, 14'h2000);

    // R5: increment ignored during write
    cyc(0,0,1,0,1,0,14'h0055);
    check("R5 addr held", addr, 14'h2000);
    rd1();
    check("R5 write landed", rd_data, 14'h0055);

    // R7, R8, R9: vector table
    for (int v = 0; v < 11; v++) begin
      logic [13:0] ta, td, te;
      logic        terr;
      {ta, td, terr, te} = VEC[v];
      go_to(ta);
      check("R3 R4 positioning", addr, ta);
      cyc(0,0,0,0,1,0,td);
      check("R8 R9 wr_err", wr_err, terr);
      idle();
      check("R9 err one cycle", wr_err, 0);
      rd1();
      check("R6 rd_valid", rd_valid, 1);
      check("R7 R8 readback", rd_data, te);
    end

    // R10, R11: bulk erase with an overlapping second strobe
    cyc(0,0,0,0,0,1,'0);
    check("R11 busy rises", busy, 1);
    n = 1;
    while (busy && n < 100) begin
      if (n == 3) cyc(0,0,0,0,0,1,'0); else idle();
      if (busy) n++;
    end
    check("R11 busy length", n, E);
    read_at("R10 user 0", 14'h0000, 14'h3FFF);
    read_at("R10 user last", 14'h07FF, 14'h3FFF);
    read_at("R10 id 0", 14'h2000, 14'h3FFF);
    read_at("R10 id 3", 14'h2003, 14'h3FFF);
    read_at("R10 cfg word", 14'h2007, 14'h3FFF);
    read_at("R10 cal0 kept", 14'h2008, CAL0);
    read_at("R10 cal1 kept", 14'h2009, 14'h1234);

    // R11: strobes during busy are ignored
    go_to(14'h2000);
    cyc(0,0,0,0,0,1,'0);
    cyc(0,0,0,0,1,0,14'h0111);
    check("R11 no wr_err while busy", wr_err, 0);
    rd1();
    check("R11 no rd_valid while busy", rd_valid, 0);
    cyc(0,1,0,0,0,0,'0);
    while (busy) idle();
    rd1();
    check("R11 write dropped", rd_data, 14'h3FFF);

    // R3: user wrap
    go_to(14'h1FFF);
    check("R3 at top", addr, 14'h1FFF);
    inc1();
    check("R3 wrap", addr, 14'h0000);

    // R4: configuration wrap and sticky region bit
    go_to(14'h3FFF);
    check("R4 at top", addr, 14'h3FFF);
    inc1();
    check("R4 wrap", addr, 14'h2000);
    inc1();
    check("R4 sticky", addr, 14'h2001);
    cyc(1,0,0,0,0,0,'0);
    check("R4 R2 reset leaves region", addr, 14'h0000);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule